// File: doc/BRIEF.md
# Scanline Band Ownership Filter

This block sits in one renderer of a multi-chip array. The screen is cut into horizontal bands of scanlines, and the bands are dealt out to the chips in rotation. Each chip runs a copy of this filter. The filter receives horizontal spans over a valid/ready handshake. A span is a scanline, a start x and a pixel count. The filter drops every span whose scanline falls in a band owned by another chip. It turns each span it keeps into a stream of two-lane work beats.

With anti-aliasing off, each beat carries two neighbouring pixels, one sample each. With two-sample anti-aliasing on, each beat carries a single pixel, with sample 0 on lane 0 and sample 1 on lane 1. The per-chip pixel rate therefore halves in that mode. The band height, the chip count, the chip index and the sample mode come from static configuration inputs. These are read only when a span is accepted.

Top module: `band_span_filter`

## Requirements
- R1: With band height 2^B (B = cfg_band_log2, 0..7) and chip count 2^C (C = cfg_chips_log2, 0..5; values above 5 act as 5), a span on scanline y is owned when ((y >> B) mod 2^C) equals cfg_chip_id. An index of 2^C or more owns nothing.
- R2: While idle, in_ready is high. A span that is not owned is accepted in one cycle, produces no beat, and leaves in_ready high.
- R3: A span with a pixel count of 0 is accepted and produces no beat, even when owned.
- R4: With cfg_aa = 0, each beat carries pixels x and x+1 (out_x0, out_x1) with out_lanes = 2'b11 and out_lane1_smp = 0. The x of successive beats rises by 2, starting at the span's start x.
- R5: With cfg_aa = 0 and an odd pixel count, the final beat has out_lanes = 2'b01, so that only lane 0 is valid.
- R6: With cfg_aa = 1, each beat carries one pixel: out_x0 = out_x1 = x, out_lanes = 2'b11, and out_lane1_smp = 1. Lane 0 holds sample 0 and lane 1 holds sample 1. The x of successive beats rises by 1.
- R7: out_last is high on the final beat of a span only. out_y equals the span's scanline on every beat. After the last beat is taken, out_valid drops in the next cycle.
- R8: While out_valid is high and out_ready is low, all output fields are held unchanged.
- R9: in_ready is low while a span is being emitted. The configuration is sampled only when a span is accepted, so a change made mid-span affects only later spans.
- R10: While rst_n is low, out_valid is low and in_ready is high. Any span in flight is discarded.
- R11: An owned span of N pixels yields ceil(N/2) beats with cfg_aa = 0, and N beats with cfg_aa = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_band_log2 | input | 3 | log2 of the band height in scanlines |
| cfg_chips_log2 | input | 3 | log2 of the chip count (clamped to 5) |
| cfg_chip_id | input | 5 | Index of this chip in the array |
| cfg_aa | input | 1 | 1 = two-sample anti-aliasing |
| in_valid | input | 1 | Span request valid |
| in_ready | output | 1 | Filter can accept a span |
| in_y | input | Y_W | Span scanline |
| in_x | input | X_W | Span start x |
| in_len | input | LEN_W | Span pixel count |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_y | output | Y_W | Beat scanline |
| out_x0 | output | X_W | Lane 0 pixel x |
| out_x1 | output | X_W | Lane 1 pixel x |
| out_lanes | output | 2 | Lane-valid mask |
| out_lane1_smp | output | 1 | Sample index carried by lane 1 |
| out_last | output | 1 | Final beat of the span |

## Verification
The bound checker watches several rules on every cycle. It checks that the beat is held while stalled and that in_ready stays low during a span. It checks the lane pairing in both modes, that a single-lane beat is always the last one, and that x advances by 2 between beats when anti-aliasing is off. It also checks that out_y holds steady within a span and that out_valid falls after the last beat. Ownership decoding, beat counts, dropped and zero-length spans, the moment configuration is latched, and reset during a span depend on the whole span history. Only the bench's directed and random scenarios, compared against its own model, can show those.

// File: rtl/band_pkg.sv
package band_pkg;
  localparam int BAND_LOG2_W   = 3;
  localparam int CHIP_LOG2_W   = 3;
  localparam int CHIP_ID_W     = 5;
  localparam int MAX_CHIP_LOG2 = 5;
  localparam int LANES         = 2;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } smp_mode_e;
endpackage

// File: rtl/band_owner.sv
module band_owner
  import band_pkg::*;
#(
  parameter int Y_W = 12
) (
  input  logic [Y_W-1:0]         y,
  input  logic [BAND_LOG2_W-1:0] band_log2,
  input  logic [CHIP_LOG2_W-1:0] chips_log2,
  input  logic [CHIP_ID_W-1:0]   chip_id,
  output logic                   owned
);
  logic [Y_W-1:0]         band_idx;
  logic [CHIP_LOG2_W-1:0] chips_eff;
  logic [CHIP_ID_W-1:0]   idx_mask;

  assign band_idx  = y >> band_log2;
  assign chips_eff = (chips_log2 > CHIP_LOG2_W'(MAX_CHIP_LOG2))
                     ? CHIP_LOG2_W'(MAX_CHIP_LOG2) : chips_log2;

  for (genvar i = 0; i < CHIP_ID_W; i++) begin : g_mask
    assign idx_mask[i] = (chips_eff > CHIP_LOG2_W'(i));
  end

  assign owned = ((band_idx[CHIP_ID_W-1:0] & idx_mask) == chip_id);
endmodule

// File: rtl/span_walker.sv
module span_walker
  import band_pkg::*;
#(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [X_W-1:0]   st_x,
  input  logic [Y_W-1:0]   st_y,
  input  logic [LEN_W-1:0] st_len,
  input  smp_mode_e        st_mode,
  input  logic             beat_ready,
  output logic             busy,
  output logic [Y_W-1:0]   beat_y,
  output logic [X_W-1:0]   beat_x0,
  output logic [X_W-1:0]   beat_x1,
  output logic [LANES-1:0] beat_lanes,
  output logic             beat_smp1,
  output logic             beat_last
);
  logic             busy_q, busy_d;
  logic [X_W-1:0]   x_q, x_d;
  logic [Y_W-1:0]   y_q, y_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  smp_mode_e        mode_q, mode_d;
  logic [LEN_W-1:0] step;
  logic             pair_ok;
  logic             load_en, adv_en, data_en;

  assign pair_ok = (rem_q >= LEN_W'(2));
  assign step    = (mode_q == MODE_DUAL) ? LEN_W'(1)
                   : (pair_ok ? LEN_W'(2) : LEN_W'(1));
  assign load_en = start & ~busy_q;
  assign adv_en  = busy_q & beat_ready;
  assign data_en = load_en | adv_en;

  assign busy       = busy_q;
  assign beat_y     = y_q;
  assign beat_x0    = x_q;
  assign beat_x1    = (mode_q == MODE_DUAL) ? x_q : X_W'(x_q + X_W'(1));
  assign beat_lanes = ((mode_q == MODE_DUAL) || pair_ok) ? 2'b11 : 2'b01;
  assign beat_smp1  = (mode_q == MODE_DUAL);
  assign beat_last  = (rem_q <= step);

  always_comb begin
    busy_d = busy_q;
    x_d    = x_q;
    y_d    = y_q;
    rem_d  = rem_q;
    mode_d = mode_q;
    if (load_en) begin
      busy_d = 1'b1;
      x_d    = st_x;
      y_d    = st_y;
      rem_d  = st_len;
      mode_d = st_mode;
    end else if (adv_en) begin
      busy_d = ~beat_last;
      x_d    = X_W'(x_q + X_W'(step));
      rem_d  = rem_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      x_q    <= x_d;
      y_q    <= y_d;
      rem_q  <= rem_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/band_span_filter.sv
module band_span_filter
  import band_pkg::*;
#(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int LEN_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BAND_LOG2_W-1:0] cfg_band_log2,
  input  logic [CHIP_LOG2_W-1:0] cfg_chips_log2,
  input  logic [CHIP_ID_W-1:0]   cfg_chip_id,
  input  logic                   cfg_aa,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [Y_W-1:0]         in_y,
  input  logic [X_W-1:0]         in_x,
  input  logic [LEN_W-1:0]       in_len,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [Y_W-1:0]         out_y,
  output logic [X_W-1:0]         out_x0,
  output logic [X_W-1:0]         out_x1,
  output logic [LANES-1:0]       out_lanes,
  output logic                   out_lane1_smp,
  output logic                   out_last
);
  logic      owned, busy, accept, start;
  smp_mode_e mode_in;

  assign mode_in  = cfg_aa ? MODE_DUAL : MODE_SINGLE;
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign start    = accept & owned & (in_len != '0);

  band_owner #(.Y_W(Y_W)) u_owner (
    .y          (in_y),
    .band_log2  (cfg_band_log2),
    .chips_log2 (cfg_chips_log2),
    .chip_id    (cfg_chip_id),
    .owned      (owned)
  );

  span_walker #(.X_W(X_W), .Y_W(Y_W), .LEN_W(LEN_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .st_x       (in_x),
    .st_y       (in_y),
    .st_len     (in_len),
    .st_mode    (mode_in),
    .beat_ready (out_ready),
    .busy       (busy),
    .beat_y     (out_y),
    .beat_x0    (out_x0),
    .beat_x1    (out_x1),
    .beat_lanes (out_lanes),
    .beat_smp1  (out_lane1_smp),
    .beat_last  (out_last)
  );

  assign out_valid = busy;
endmodule

// File: rtl/band_span_filter_chk.sv
module band_span_filter_chk #(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Y_W-1:0] out_y,
  input logic [X_W-1:0] out_x0,
  input logic [X_W-1:0] out_x1,
  input logic [1:0]     out_lanes,
  input logic           out_lane1_smp,
  input logic           out_last
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_idle: assert (!out_valid && in_ready);
    end
  end

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x0) && $stable(out_x1)
      && $stable(out_y) && $stable(out_lanes) && $stable(out_last)
      && $stable(out_lane1_smp));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r5_single_tail: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_lanes == 2'b01 |-> out_last && !out_lane1_smp);

  a_r6_sample_pair: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_lane1_smp |-> out_x1 == out_x0 && out_lanes == 2'b11);

  a_r4_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_lane1_smp && out_lanes == 2'b11 |-> out_x1 == X_W'(out_x0 + 1'b1));

  a_r4_stride: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && !out_lane1_smp
      |=> out_x0 == X_W'($past(out_x0) + 2'd2));

  a_r7_same_row: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && $stable(out_y));

  a_r7_end_drop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

bind band_span_filter band_span_filter_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (.*);

// File: tb/sim_band_span_filter.sv
module sim_band_span_filter;
  localparam int X_W = 12, Y_W = 12, LEN_W = 12;

  logic clk, rst_n;
  logic [2:0] cfg_band_log2, cfg_chips_log2;
  logic [4:0] cfg_chip_id;
  logic cfg_aa, in_valid, in_ready, out_valid, out_ready;
  logic [Y_W-1:0] in_y, out_y;
  logic [X_W-1:0] in_x, out_x0, out_x1;
  logic [LEN_W-1:0] in_len;
  logic [1:0] out_lanes;
  logic out_lane1_smp, out_last;

  int n_chk, n_fail;
  bit done;

  band_span_filter #(.X_W(X_W), .Y_W(Y_W), .LEN_W(LEN_W)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_owned(input int y);
    int c;
    c = (cfg_chips_log2 > 5) ? 5 : int'(cfg_chips_log2);
    return ((y >> cfg_band_log2) % (1 << c)) == int'(cfg_chip_id);
  endfunction

  // drive one span and consume all its beats, checking each against the model
  task automatic run_span(input int y, input int x, input int len, input bit flip);
    bit own, aa;
    int nb, k, guard;
    own = exp_owned(y);
    aa  = cfg_aa;
    nb  = (own && len != 0) ? (aa ? len : (len + 1) / 2) : 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);
    in_valid = 1'b1; in_y = Y_W'(y); in_x = X_W'(x); in_len = LEN_W'(len);
    @(negedge clk);
    in_valid = 1'b0;
    if (flip) cfg_aa = ~cfg_aa;  // R9: mid-span config change
    k = 0; guard = 0;
    while (k < nb && guard < 400) begin
      int ex0, ex1, rem;
      bit elast;
      guard++;
      out_ready = ($urandom % 4) != 0;
      rem   = aa ? (len - k) : (len - 2 * k);
      ex0   = aa ? (x + k) % (1 << X_W) : (x + 2 * k) % (1 << X_W);
      ex1   = aa ? ex0 : (ex0 + 1) % (1 << X_W);
      elast = (k == nb - 1);
      chk(out_valid == 1'b1, "R11 beat present", int'(out_valid), 1);
      chk(int'(out_x0) == ex0, aa ? "R6 x0" : "R4 x0", int'(out_x0), ex0);
      chk(int'(out_y) == (y % (1 << Y_W)), "R7 y", int'(out_y), y);
      chk(out_last == elast, "R7 last", int'(out_last), int'(elast));
      if (aa) begin
        chk(out_lanes == 2'b11 && out_lane1_smp && int'(out_x1) == ex1,
            "R6 lanes/sample", int'({out_lanes, out_lane1_smp}), 7);
      end else if (rem >= 2) begin
        chk(out_lanes == 2'b11 && !out_lane1_smp && int'(out_x1) == ex1,
            "R4 pair", int'(out_x1), ex1);
      end else begin
        chk(out_lanes == 2'b01, "R5 odd tail", int'(out_lanes), 1);
      end
      @(posedge clk);
      if (out_ready) k++;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(out_valid == 1'b0, own && len != 0 ? "R11 no extra beat" :
        (len == 0 ? "R3 zero length silent" : "R2 foreign silent"), int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 ready after span", int'(in_ready), 1);
  endtask

  task automatic set_cfg(input int b, input int c, input int id, input bit aa);
    cfg_band_log2 = 3'(b); cfg_chips_log2 = 3'(c); cfg_chip_id = 5'(id); cfg_aa = aa;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_y = '0; in_x = '0; in_len = '0;
    set_cfg(5, 1, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset state",
        int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;

    // R1: band height 32, two chips, this is chip 0
    run_span(0, 10, 4, 0);
    run_span(31, 10, 4, 0);
    run_span(32, 10, 4, 0);   // chip 1 band: dropped (R2)
    run_span(64, 10, 4, 0);
    set_cfg(0, 5, 31, 1'b0);
    run_span(31, 100, 6, 0);  // R1 height 1, 32 chips
    run_span(63, 100, 6, 0);
    run_span(30, 100, 6, 0);
    set_cfg(2, 7, 9, 1'b0);   // R1 count clamp to 32
    run_span(9 * 4 + 3, 5, 3, 0);
    set_cfg(0, 1, 3, 1'b0);   // id outside array owns nothing
    run_span(1, 5, 3, 0);
    run_span(3, 5, 3, 0);
    // R5 odd lengths, R3 zero length
    set_cfg(3, 0, 0, 1'b0);
    run_span(7, 20, 5, 0);
    run_span(7, 20, 1, 0);
    run_span(7, 20, 0, 0);
    run_span(7, 4094, 4, 0);  // x wraps
    // R6 anti-aliasing
    set_cfg(3, 0, 0, 1'b1);
    run_span(7, 40, 3, 0);
    run_span(7, 40, 0, 0);
    // R9 mid-span change of mode
    run_span(7, 50, 5, 1);
    run_span(7, 50, 5, 1);

    // R10 reset during a span
    @(negedge clk);
    in_valid = 1'b1; in_y = '0; in_x = '0; in_len = 12'd20;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 span started", int'(out_valid), 1);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset clears span",
        int'({out_valid, in_ready}), 1);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 stays idle", int'(out_valid), 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int c;
      c = $urandom % 8;
      set_cfg($urandom % 8, c, ($urandom % 5 == 0) ? $urandom % 32
              : $urandom % (1 << ((c > 5) ? 5 : c)), $urandom % 2);
      run_span($urandom % 4096, $urandom % 4096, $urandom % 21, ($urandom % 6) == 0);
    end
    finish_run();
  end
endmodule